// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small fully associative store of taken branches. During instruction fetch it is looked up with the fetch address. When a valid entry's full address tag matches, the block returns that entry's stored target as the next fetch address, together with a small confidence count. When no entry matches, the next fetch address is the fetch address plus four. Because only branches that last resolved taken are held, a miss simply means sequential fetch.

Branch outcomes come back through an update port. A taken branch that is not stored is written into the slot named by a round-robin pointer. A taken branch that is already stored gets its target refreshed and its count raised. A stored branch that resolves not taken is dropped. The lookup is purely combinational on registered contents, so a lookup and an update in the same cycle see the contents from before the update.

Top module: `btb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup whose address equals the tag of a valid entry asserts `lk_hit`, drives that entry's target on `lk_next_pc` and its count on `lk_state`.
- R3: A lookup that misses drives `lk_pc + 4` (modulo 2^PC_W) on `lk_next_pc` and zero on `lk_state`.
- R4: A taken update (`up_valid`=1, `up_taken`=1) for an address not held writes a valid entry with that tag, that target and count 1. The entry is visible from the next cycle.
- R5: A taken update for an address already held replaces its target and raises its count by one, saturating at 2^ST_W-1 (3 by default).
- R6: A not-taken update (`up_valid`=1, `up_taken`=0) for an address already held invalidates that entry, so the next lookup of that address misses.
- R7: A not-taken update for an address not held changes nothing.
- R8: Allocation uses a round-robin slot pointer that starts at slot 0 after reset and advances by one, wrapping, only on an allocation. With 16 slots, the 17th allocation after reset evicts the first one.
- R9: A lookup in the same cycle as an update returns the result from before that update.
- R10: With `up_valid`=0 the contents do not change.
- R11: No address ever occupies more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address looked up |
| lk_hit | output | 1 | A valid entry matches `lk_pc` |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| lk_state | output | ST_W | Count of the matching entry, zero on a miss |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | Address of the resolved branch |
| up_target | input | PC_W | Actual target of the resolved branch |
| up_taken | input | 1 | 1 if the branch resolved taken |

## Verification
The properties take for granted that `up_pc`, `up_target` and `up_taken` carry known values whenever `up_valid` is high and that `lk_pc` is always known. They also assume one update per cycle, which the port itself enforces. The stimulus drives every input to a defined value on every cycle, including when `up_valid` is low, and draws branch addresses from a small pool. This makes repeated allocation, refresh, invalidation and pointer wrap-around frequent, while the reference model follows each of these cases.

// File: rtl/btb.sv
module btb #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int ST_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_next_pc,
  output logic [ST_W-1:0] lk_state,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_taken
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ST_W-1:0] ST_MAX = {ST_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [ST_W-1:0]    st_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] lk_match, up_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = vld[i] && (tag_q[i] == lk_pc);
    assign up_match[i] = vld[i] && (tag_q[i] == up_pc);
  end

  logic [PC_W-1:0] sel_tgt;
  logic [ST_W-1:0] sel_st;
  logic [IDX_W-1:0] up_idx;

  always_comb begin
    sel_tgt = '0;
    sel_st  = '0;
    up_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_tgt = sel_tgt | tgt_q[i];
        sel_st  = sel_st  | st_q[i];
      end
      if (up_match[i]) up_idx = IDX_W'(i);
    end
  end

  assign lk_hit     = |lk_match;
  assign lk_next_pc = lk_hit ? sel_tgt : lk_pc + PC_W'(4);
  assign lk_state   = sel_st;

  wire up_hit = |up_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      rr_q <= '0;
    end else if (up_valid) begin
      if (up_hit) begin
        if (up_taken) begin
          tgt_q[up_idx] <= up_target;
          if (st_q[up_idx] != ST_MAX) st_q[up_idx] <= st_q[up_idx] + 1'b1;
        end else begin
          vld[up_idx] <= 1'b0;
        end
      end else if (up_taken) begin
        vld[rr_q]   <= 1'b1;
        tag_q[rr_q] <= up_pc;
        tgt_q[rr_q] <= up_target;
        st_q[rr_q]  <= ST_W'(1);
        rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
    end
  end
endmodule

module btb_checker #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int ST_W    = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic [PC_W-1:0] lk_next_pc,
  input logic [ST_W-1:0] lk_state,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic [PC_W-1:0] up_target,
  input logic            up_taken,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] up_match
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lk_hit);

  assert_hit_has_count_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_state != '0);

  assert_taken_visible_R4: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken) |=>
      (lk_pc != $past(up_pc) || (lk_hit && lk_next_pc == $past(up_target))));

  assert_not_taken_gone_R6: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken) |=> (lk_pc != $past(up_pc) || !lk_hit));

  assert_unique_tag_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match) && $onehot0(up_match));
endmodule

bind btb btb_checker #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ST_W(ST_W)) u_btb_checker (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_next_pc(lk_next_pc),
  .lk_state(lk_state), .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
  .up_taken(up_taken), .lk_match(lk_match), .up_match(up_match)
);

// File: tb/btb_bench.sv
module btb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic [31:0] lk_next_pc;
  logic [1:0]  lk_state;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [31:0] up_target = '0;
  logic        up_taken = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb u_btb (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_next_pc(lk_next_pc),
    .lk_state(lk_state), .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
    .up_taken(up_taken)
  );

  int checks = 0;
  int errors = 0;

  bit          m_vld [N];
  logic [31:0] m_tag [N];
  logic [31:0] m_tgt [N];
  int          m_st  [N];
  int          m_rr;

  function automatic int find(logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_rr = 0;
  endtask

  task automatic model_update();
    int k;
    if (!up_valid) return;
    k = find(up_pc);
    if (k >= 0) begin
      if (up_taken) begin
        m_tgt[k] = up_target;
        if (m_st[k] < 3) m_st[k]++;
      end else m_vld[k] = 0;
    end else if (up_taken) begin
      m_vld[m_rr] = 1; m_tag[m_rr] = up_pc; m_tgt[m_rr] = up_target; m_st[m_rr] = 1;
      m_rr = (m_rr + 1) % N;
    end
  endtask

  task automatic step(string req, logic [31:0] lpc, logic uv, logic [31:0] upc,
                      logic [31:0] utg, logic utk);
    int k;
    logic        e_hit;
    logic [31:0] e_next;
    logic [1:0]  e_st;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_target = utg; up_taken = utk;
    #1;
    k = find(lpc);
    e_hit  = (k >= 0);
    e_next = e_hit ? m_tgt[k] : lpc + 32'd4;
    e_st   = e_hit ? 2'(m_st[k]) : 2'd0;
    checks++;
    if (lk_hit !== e_hit || lk_next_pc !== e_next || lk_state !== e_st) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b next=%h st=%0d expected hit=%b next=%h st=%0d",
               req, lpc, lk_hit, lk_next_pc, lk_state, e_hit, e_next, e_st);
    end
    @(posedge clk);
    model_update();
  endtask

  task automatic look(string req, logic [31:0] lpc);
    step(req, lpc, 1'b0, 32'h0, 32'h0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    look("R1", 32'h0000_1000);
    look("R1", 32'h0000_0000);
    look("R3", 32'hFFFF_FFFC);

    step("R9", 32'h0000_1000, 1, 32'h0000_1000, 32'h0000_2000, 1);
    look("R4", 32'h0000_1000);
    look("R2", 32'h0000_1000);

    step("R7", 32'h0000_1100, 1, 32'h0000_1100, 32'h0000_3000, 0);
    look("R7", 32'h0000_1100);
    look("R7", 32'h0000_1000);

    step("R5", 32'h0000_1000, 1, 32'h0000_1000, 32'h0000_2400, 1);
    look("R5", 32'h0000_1000);
    step("R5", 32'h0000_1000, 1, 32'h0000_1000, 32'h0000_2800, 1);
    step("R5", 32'h0000_1000, 1, 32'h0000_1000, 32'h0000_2800, 1);
    look("R5", 32'h0000_1000);

    step("R10", 32'h0000_1000, 0, 32'h0000_1000, 32'h0000_9000, 0);
    look("R10", 32'h0000_1000);

    step("R9", 32'h0000_1000, 1, 32'h0000_1000, 32'h0, 0);
    look("R6", 32'h0000_1000);

    for (int i = 0; i < 17; i++)
      step("R8", 32'h0, 1, 32'h0004_0000 + 32'(i*8), 32'h0008_0000 + 32'(i*16), 1);
    look("R8", 32'h0004_0000);
    look("R8", 32'h0004_0008);
    look("R8", 32'h0004_0080);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = 32'h0000_5000 + 32'($urandom_range(0, 23) * 4);
      b = 32'h0000_5000 + 32'($urandom_range(0, 23) * 4);
      step("R2", a, 1'($urandom_range(0, 3) != 0), b,
           32'h0000_7000 + 32'($urandom_range(0, 255) * 4), 1'($urandom_range(0, 2) != 0));
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    look("R1", 32'h0000_5000);
    look("R1", 32'h0004_0008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule